// File: doc/BRIEF.md
# Microcoded Datapath ALU with Result Shifter

This block is the arithmetic stage of a microcoded 32-bit datapath. The left operand comes from a holding register and the right operand from a shared source bus. A handful of independent control bits build every operation: two operand enables, a complement of the left operand, a carry-in bit, and a 2-bit function select. Together they give AND, OR, NOT, add, increment, subtract, negate and the constants 0, 1 and -1. A shifter follows the function unit. It can move the result up by one byte or down by one bit with the sign kept.

The negative and zero flags describe the function unit's value before it reaches the shifter. This is the value a microsequencer branches on. All outputs are registered, so a new control word and operand pair can be applied on every clock, and the result appears one edge later. If both shift controls are set at once, the value passes through unshifted and a conflict output is raised.

Top module: `uop_alu`

## Requirements
- R1: While `rst_n` is low, `result_q`, `neg_q`, `zero_q` and `shift_conflict_q` are all 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge and holds steady between edges.
- R3: When `en_a` is low the left operand is zero, and when `en_b` is low the right operand is zero. When `inv_a` is high the gated left operand is bitwise complemented before use.
- R4: `f_sel` = 2'b00 gives A AND B, 2'b01 gives A OR B, and 2'b10 gives NOT B, all on the gated operands.
- R5: `f_sel` = 2'b11 gives A + B + `carry_in` modulo 2^32; the carry out of bit 31 is discarded. With all four operand controls high, this is B - A.
- R6: With only `shl_byte` high, the result is the function value shifted up by 8 bits with zeroes in bits 7:0.
- R7: With only `sar_one` high, the result is the function value shifted down by 1 bit, with bit 31 copied into both bit 31 and bit 30.
- R8: With both shift controls high, the function value passes unshifted and `shift_conflict_q` is 1. Otherwise `shift_conflict_q` is 0.
- R9: `neg_q` equals bit 31 of the function value before shifting.
- R10: `zero_q` is 1 exactly when the function value before shifting is all zeroes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_hold | input | 32 | Left operand from the holding register |
| b_bus | input | 32 | Right operand from the source bus |
| f_sel | input | 2 | Function select (00 AND, 01 OR, 10 NOT B, 11 sum) |
| en_a | input | 1 | Left operand enable |
| en_b | input | 1 | Right operand enable |
| inv_a | input | 1 | Complement the gated left operand |
| carry_in | input | 1 | Carry into the sum |
| shl_byte | input | 1 | Shift result up by one byte |
| sar_one | input | 1 | Shift result down by one bit, arithmetic |
| result_q | output | 32 | Registered shifted result |
| neg_q | output | 1 | Registered sign of the unshifted value |
| zero_q | output | 1 | Registered zero test of the unshifted value |
| shift_conflict_q | output | 1 | Both shift controls were set |

## Verification
The hardest case to reach is one where the flags disagree with the visible result. A byte shift can push every set bit out of the word, so `result_q` reads zero while `zero_q` is 0 and `neg_q` is 1. The arithmetic shift can do the reverse and spread the sign into bits the function unit left clear. The stimulus drives directed operands whose only set bits lie in the top byte, and sign-boundary values through the right shift. A long run of random control words then mixes every combination of enables, complement, carry-in and the conflicting shift pair. Each result is compared against a behavioural model in the bench.

// File: rtl/uop_alu_pkg.sv
package uop_alu_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } fn_e;

    // Encoding is {sar_one, shl_byte}
    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_BOTH  = 2'b11
    } shmode_e;

endpackage

// File: rtl/uop_alu_logic.sv
module uop_alu_logic
    import uop_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  fn_e              fn,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             inv_a,
    input  logic             cin,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] a_gated;
    logic [WIDTH-1:0] a_op;
    logic [WIDTH-1:0] b_op;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] carry;

    always_comb begin
        a_gated = en_a ? a_in : '0;
        a_op    = inv_a ? ~a_gated : a_gated;
        b_op    = en_b ? b_in : '0;
    end

    // Explicit ripple chain; carry out of the top bit is never formed
    assign carry[0] = cin;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i] = a_op[i] ^ b_op[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_carry
            assign carry[i+1] = (a_op[i] & b_op[i]) | (carry[i] & (a_op[i] ^ b_op[i]));
        end
    end

    always_comb begin
        unique case (fn)
            FN_AND:  y = a_op & b_op;
            FN_OR:   y = a_op | b_op;
            FN_NOTB: y = ~b_op;
            default: y = sum;
        endcase
    end

endmodule

// File: rtl/uop_alu_shift.sv
module uop_alu_shift
    import uop_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHL_AMT = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic             shl,
    input  logic             shr,
    output logic [WIDTH-1:0] y,
    output logic             conflict
);

    shmode_e mode;

    always_comb begin
        mode     = shmode_e'({shr, shl});
        conflict = (mode == SH_BOTH);
        unique case (mode)
            SH_LEFT:  y = {x[WIDTH-SHL_AMT-1:0], {SHL_AMT{1'b0}}};
            SH_RIGHT: y = {x[WIDTH-1], x[WIDTH-1:1]};
            default:  y = x;
        endcase
    end

endmodule

// File: rtl/uop_alu.sv
module uop_alu
    import uop_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHL_AMT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_hold,
    input  logic [WIDTH-1:0] b_bus,
    input  logic [1:0]       f_sel,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             inv_a,
    input  logic             carry_in,
    input  logic             shl_byte,
    input  logic             sar_one,
    output logic [WIDTH-1:0] result_q,
    output logic             neg_q,
    output logic             zero_q,
    output logic             shift_conflict_q
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             neg;
        logic             zero;
        logic             conflict;
        logic [1:0]       mode;
    } stage_t;

    stage_t           st_d, st_q;
    logic [WIDTH-1:0] fn_y;
    logic [WIDTH-1:0] sh_y;
    logic             sh_conflict;

    uop_alu_logic #(.WIDTH(WIDTH)) logic_i (
        .a_in  (a_hold),
        .b_in  (b_bus),
        .fn    (fn_e'(f_sel)),
        .en_a  (en_a),
        .en_b  (en_b),
        .inv_a (inv_a),
        .cin   (carry_in),
        .y     (fn_y)
    );

    uop_alu_shift #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) shift_i (
        .x        (fn_y),
        .shl      (shl_byte),
        .shr      (sar_one),
        .y        (sh_y),
        .conflict (sh_conflict)
    );

    always_comb begin
        st_d          = st_q;
        st_d.res      = sh_y;
        st_d.neg      = fn_y[MSB];
        st_d.zero     = (fn_y == '0);
        st_d.conflict = sh_conflict;
        st_d.mode     = {sar_one, shl_byte};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_q         = st_q.res;
    assign neg_q            = st_q.neg;
    assign zero_q           = st_q.zero;
    assign shift_conflict_q = st_q.conflict;

    // A zero pre-shift value stays zero through any shift
    p_zero_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_q |-> (result_q == '0));

    // Byte shift must leave the low byte clear
    p_left_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SH_LEFT) |-> (result_q[SHL_AMT-1:0] == '0));

    // Arithmetic shift keeps the sign seen by the flag
    p_right_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SH_RIGHT) |-> (result_q[MSB] == neg_q && result_q[MSB-1] == neg_q));

    // Conflicting shift request passes the value through
    p_conflict_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_conflict_q |-> (result_q[MSB] == neg_q && st_q.mode == SH_BOTH));

    // Unshifted output carries the sign flag in its top bit
    p_neg_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == SH_NONE) |-> (result_q[MSB] == neg_q && !shift_conflict_q));

endmodule

// File: tb/uop_alu_tb_top.sv
module uop_alu_tb_top;

    logic        clk;
    logic        rst_n;
    logic [31:0] a_hold, b_bus;
    logic [1:0]  f_sel;
    logic        en_a, en_b, inv_a, carry_in, shl_byte, sar_one;
    logic [31:0] result_q;
    logic        neg_q, zero_q, shift_conflict_q;

    int checks   = 0;
    int failures = 0;

    logic [31:0] exp_res;
    logic        exp_neg, exp_zero, exp_conf;

    uop_alu dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .a_hold           (a_hold),
        .b_bus            (b_bus),
        .f_sel            (f_sel),
        .en_a             (en_a),
        .en_b             (en_b),
        .inv_a            (inv_a),
        .carry_in         (carry_in),
        .shl_byte         (shl_byte),
        .sar_one          (sar_one),
        .result_q         (result_q),
        .neg_q            (neg_q),
        .zero_q           (zero_q),
        .shift_conflict_q (shift_conflict_q)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic [1:0] f,
                         logic ea, logic eb, logic ia, logic ci, logic sl, logic sr);
        a_hold = a; b_bus = b; f_sel = f;
        en_a = ea; en_b = eb; inv_a = ia; carry_in = ci;
        shl_byte = sl; sar_one = sr;
    endtask

    // Behavioural model of one operation
    task automatic model(logic [31:0] a, logic [31:0] b, logic [1:0] f,
                         logic ea, logic eb, logic ia, logic ci, logic sl, logic sr);
        logic [31:0] ao, bo, fv;
        logic [63:0] wide;
        ao = ea ? a : 32'd0;
        if (ia) ao = ~ao;
        bo = eb ? b : 32'd0;
        case (f)
            2'b00:   fv = ao & bo;
            2'b01:   fv = ao | bo;
            2'b10:   fv = ~bo;
            default: begin
                wide = 64'(ao) + 64'(bo) + 64'(ci);
                fv = wide[31:0];
            end
        endcase
        if (sl && !sr)      exp_res = fv << 8;
        else if (sr && !sl) exp_res = $signed(fv) >>> 1;
        else                exp_res = fv;
        exp_neg  = fv[31];
        exp_zero = (fv == 32'd0);
        exp_conf = sl && sr;
    endtask

    task automatic run_op(string tag, logic [31:0] a, logic [31:0] b, logic [1:0] f,
                          logic ea, logic eb, logic ia, logic ci, logic sl, logic sr);
        drive(a, b, f, ea, eb, ia, ci, sl, sr);
        model(a, b, f, ea, eb, ia, ci, sl, sr);
        @(posedge clk);
        #1;
        chk(tag, "result", result_q, exp_res);
        chk(tag, "neg", 32'(neg_q), 32'(exp_neg));
        chk(tag, "zero", 32'(zero_q), 32'(exp_zero));
        chk(tag, "conflict", 32'(shift_conflict_q), 32'(exp_conf));
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(32'hDEADBEEF, 32'h12345678, 2'b11, 1, 1, 0, 1, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        // R1: all outputs zero during reset
        chk("R1", "result", result_q, 32'd0);
        chk("R1", "neg", 32'(neg_q), 32'd0);
        chk("R1", "zero", 32'(zero_q), 32'd0);
        chk("R1", "conflict", 32'(shift_conflict_q), 32'd0);
        rst_n = 1'b1;

        // R4: logic functions
        run_op("R4", 32'hF0F0_1234, 32'hFF00_FF0F, 2'b00, 1, 1, 0, 0, 0, 0);
        run_op("R4", 32'hF0F0_1234, 32'h0F00_0F0F, 2'b01, 1, 1, 0, 0, 0, 0);
        run_op("R4", 32'h1111_1111, 32'h0000_FFFF, 2'b10, 0, 1, 0, 0, 0, 0);
        run_op("R4", 32'hAAAA_AAAA, 32'h8765_4321, 2'b01, 0, 1, 0, 0, 0, 0);
        // R3: gating and complement
        run_op("R3", 32'h8765_4321, 32'hFFFF_FFFF, 2'b01, 1, 0, 0, 0, 0, 0);
        run_op("R3", 32'h8765_4321, 32'hFFFF_FFFF, 2'b01, 1, 0, 1, 0, 0, 0);
        run_op("R3", 32'h8765_4321, 32'hFFFF_FFFF, 2'b01, 0, 0, 0, 0, 0, 0);
        run_op("R3", 32'h8765_4321, 32'h1234_5678, 2'b01, 0, 0, 1, 0, 0, 0);
        run_op("R3", 32'h8765_4321, 32'h0000_0005, 2'b11, 0, 1, 0, 1, 0, 0);
        // R5: arithmetic
        run_op("R5", 32'd100, 32'd23, 2'b11, 1, 1, 0, 0, 0, 0);
        run_op("R5", 32'd100, 32'd23, 2'b11, 1, 1, 0, 1, 0, 0);
        run_op("R5", 32'd7, 32'd23, 2'b11, 1, 1, 1, 1, 0, 0);
        run_op("R5", 32'd30, 32'd7, 2'b11, 1, 1, 1, 1, 0, 0);
        run_op("R5", 32'd9, 32'd0, 2'b11, 0, 1, 1, 0, 0, 0);
        run_op("R5", 32'd9, 32'd0, 2'b11, 1, 0, 1, 1, 0, 0);
        run_op("R5", 32'd9, 32'd9, 2'b11, 0, 0, 0, 1, 0, 0);
        run_op("R5", 32'hFFFF_FFFF, 32'd0, 2'b11, 1, 0, 0, 1, 0, 0);
        run_op("R5", 32'h8000_0000, 32'h8000_0000, 2'b11, 1, 1, 0, 0, 0, 0);
        // R6: byte shift, including bits pushed out entirely
        run_op("R6", 32'h0, 32'h1234_5678, 2'b01, 0, 1, 0, 0, 1, 0);
        run_op("R6", 32'h0, 32'hFF00_0000, 2'b01, 0, 1, 0, 0, 1, 0);
        // R7: arithmetic right shift
        run_op("R7", 32'h0, 32'h8000_0001, 2'b01, 0, 1, 0, 0, 0, 1);
        run_op("R7", 32'h0, 32'h4000_0002, 2'b01, 0, 1, 0, 0, 0, 1);
        run_op("R7", 32'h0, 32'h0000_0001, 2'b01, 0, 1, 0, 0, 0, 1);
        // R8: conflicting shift request
        run_op("R8", 32'h0, 32'h8123_4567, 2'b01, 0, 1, 0, 0, 1, 1);
        // R9 / R10: flags follow the unshifted value
        run_op("R9", 32'h0, 32'h0080_0000, 2'b01, 0, 1, 0, 0, 1, 0);
        run_op("R10", 32'h0, 32'h0, 2'b10, 0, 0, 0, 0, 0, 1);

        // R2: outputs hold between edges after inputs change
        run_op("R2", 32'h5, 32'h6, 2'b11, 1, 1, 0, 0, 0, 0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1, 1, 0, 0, 1, 1);
        #3;
        chk("R2", "held result", result_q, exp_res);
        chk("R2", "held conflict", 32'(shift_conflict_q), 32'(exp_conf));

        // R2: random control words, result checked one edge later
        for (int i = 0; i < 500; i++) begin
            logic [9:0] c;
            c = 10'($urandom);
            run_op("R2", $urandom, $urandom, c[1:0], c[2], c[3], c[4], c[5], c[6], c[7]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule